// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Bank

This block is the programmable state of a four-channel DMA controller, reached through a byte-wide I/O port with a 4-bit offset. Each channel has 16-bit base and current registers for its address and its count. These are moved one byte at a time, and a shared byte-pointer flip-flop picks which byte. A write to an address or count port fills the base and current copies together. The bank also keeps a command byte, a request byte, a status nibble of per-channel completion flags, a temporary register, a six-bit mode per channel and a four-bit channel mask.

A transfer sequencer beside the bank reads the current address, count, mode, mask, command and request values from flat output buses. It drives per-channel strobes back to the bank that decrement a count, step an address up or down, reload the current copies from base, flag a channel as finished, or mask a channel. When a sequencer strobe and a CPU write hit the same register in one cycle, the sequencer wins. The port is synchronous. Read data is registered and appears the cycle after the read strobe.

Top module: `dmac_regbank`

## Requirements
- R1: After hardware reset all four mask bits are set, the mask read at offset 15 returns 0x0F, the status read at offset 8 returns 0x00, and every current address and count is zero.
- R2: Two writes to offset 2*n (address) or 2*n+1 (count) of channel n load the low byte and then the high byte into both the base and current copies. The first byte after the pointer is cleared is the low byte.
- R3: A read of offset 2*n or 2*n+1 returns the low byte of the current register while the byte pointer is 0, and the high byte while it is 1. Every channel-register read or write toggles the pointer, and a write to offset 12 clears it.
- R4: rdata changes only on the cycle after an accepted read (rd high, wr low) and otherwise holds its value.
- R5: A write to offset 11 stores data bits 7:2 as the mode of the channel given by data bits 1:0. The other channels' modes are unchanged.
- R6: A write to offset 10 selects the mask bit with data bits 1:0. It sets that bit if data bit 2 is 1 and clears it if data bit 2 is 0.
- R7: A write to offset 15 loads the mask from data bits 3:0, a read of offset 15 returns the mask in bits 3:0, and a write to offset 14 clears the whole mask.
- R8: A write to offset 13 clears command, request, status, the temporary register and the byte pointer, and sets all mask bits. Modes and address and count registers keep their values. A read of offset 13 returns the temporary register (0x00).
- R9: Reads of the write-only offsets 9, 10, 11, 12 and 14 return 0x00.
- R10: Sequencer strobes decrement the current count, increment or decrement the current address, or reload both current copies from base (reload wins over step and decrement). Such a strobe takes priority over a CPU byte write to the same current register in the same cycle, while the base byte is still written.
- R11: A sequencer done strobe sets channel n's bit n of the status read at offset 8. A sequencer mask strobe sets mask bit n even when the CPU clears that bit in the same cycle.
- R12: Writes to offset 8 and offset 9 load the command and request bytes seen on cmd_o and req_o. A read of offset 8 still returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| ofs | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| seq_cnt_dec | input | 4 | Per-channel count decrement strobe |
| seq_addr_inc | input | 4 | Per-channel address increment strobe |
| seq_addr_dec | input | 4 | Per-channel address decrement strobe |
| seq_reload | input | 4 | Per-channel reload of current from base |
| seq_set_done | input | 4 | Per-channel status flag set |
| seq_set_mask | input | 4 | Per-channel mask bit set |
| cur_addr_o | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_cnt_o | output | 64 | Current counts, channel n at bits 16n+15:16n |
| mode_o | output | 24 | Modes, channel n at bits 6n+5:6n |
| mask_o | output | 4 | Channel mask |
| cmd_o | output | 8 | Command byte |
| req_o | output | 8 | Request byte |

## Verification
The byte-pointer path is tested with paired writes and with reads broken by a pointer clear, so a pointer that never toggles or never clears returns the wrong byte. The mask is driven through all its write paths: single set and clear, full load, clear all, master reset, and a CPU clear that collides with a sequencer set. Each path alone separates a different fault. Sequencer strobes run alone and together with a CPU write to the same channel, so the priority order and the fact that the base copy is still written can both be seen on the outputs.

// File: rtl/dmac_pkg.sv
// Package: shared constants for the DMA register bank.
// Assumes a 4-bit offset space and exactly four channels.
package dmac_pkg;
    localparam int unsigned NCH   = 4;
    localparam int unsigned OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_CMD_STAT = 4'd8;
    localparam logic [OFS_W-1:0] OFS_REQ      = 4'd9;
    localparam logic [OFS_W-1:0] OFS_MASK_ONE = 4'd10;
    localparam logic [OFS_W-1:0] OFS_MODE     = 4'd11;
    localparam logic [OFS_W-1:0] OFS_PTR_CLR  = 4'd12;
    localparam logic [OFS_W-1:0] OFS_MRESET   = 4'd13;
    localparam logic [OFS_W-1:0] OFS_MASK_CLR = 4'd14;
    localparam logic [OFS_W-1:0] OFS_MASK_ALL = 4'd15;

    // Offsets 0..7 address the per-channel address/count registers.
    function automatic logic is_chan_ofs(input logic [OFS_W-1:0] o);
        return (o[OFS_W-1] == 1'b0);
    endfunction
endpackage

// File: rtl/dmac_chan.sv
// Module: one channel's base/current address and count registers.
// Assumes: CPU byte writes load base and current together; sequencer
// strobes act on current copies only and win over a CPU byte write.
module dmac_chan #(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_addr,
    input  logic              cpu_wr_cnt,
    input  logic              byte_hi,
    input  logic [DW-1:0]     wdata,
    input  logic              addr_inc,
    input  logic              addr_dec,
    input  logic              cnt_dec,
    input  logic              reload,
    output logic [2*DW-1:0]   cur_addr,
    output logic [2*DW-1:0]   cur_cnt
);
    localparam int unsigned RW = 2 * DW;

    logic [RW-1:0] base_addr;
    logic [RW-1:0] base_cnt;

    // Merge one CPU byte into a 16-bit value at the pointer position.
    function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] old,
                                               input logic hi,
                                               input logic [DW-1:0] b);
        return hi ? {b, old[DW-1:0]} : {old[RW-1:DW], b};
    endfunction

    // Base address: only CPU byte writes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)           base_addr <= '0;
        else if (cpu_wr_addr) base_addr <= put_byte(base_addr, byte_hi, wdata);
    end

    // Base count: only CPU byte writes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)          base_cnt <= '0;
        else if (cpu_wr_cnt) base_cnt <= put_byte(base_cnt, byte_hi, wdata);
    end

    // Current address: reload, then step, then CPU byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)           cur_addr <= '0;
        else if (reload)      cur_addr <= base_addr;
        else if (addr_inc)    cur_addr <= cur_addr + 1'b1;
        else if (addr_dec)    cur_addr <= cur_addr - 1'b1;
        else if (cpu_wr_addr) cur_addr <= put_byte(cur_addr, byte_hi, wdata);
    end

    // Current count: reload, then decrement, then CPU byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_cnt <= '0;
        else if (reload)     cur_cnt <= base_cnt;
        else if (cnt_dec)    cur_cnt <= cur_cnt - 1'b1;
        else if (cpu_wr_cnt) cur_cnt <= put_byte(cur_cnt, byte_hi, wdata);
    end
endmodule

// File: rtl/dmac_ctrl.sv
// Module: controller-wide registers: command, request, status, temporary,
// modes, mask and the byte-pointer flip-flop.
// Assumes: a write wins over a read in the same cycle; sequencer set strobes
// win over CPU writes and master reset for the bits they touch.
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic                    rd_ok,
    input  logic [OFS_W-1:0]        ofs,
    input  logic [DW-1:0]           wdata,
    input  logic [NCH-1:0]          seq_set_done,
    input  logic [NCH-1:0]          seq_set_mask,
    output logic [DW-1:0]           cmd,
    output logic [DW-1:0]           req,
    output logic [NCH-1:0]          stat,
    output logic [DW-1:0]           temp,
    output logic [NCH-1:0]          mask,
    output logic [NCH*(DW-2)-1:0]   modes,
    output logic                    byte_hi
);
    localparam int unsigned MODE_W = DW - 2;

    logic mreset;
    logic chan_access;
    logic [NCH-1:0] sel_onehot;

    assign mreset      = wr && (ofs == OFS_MRESET);
    assign chan_access = (wr || rd_ok) && is_chan_ofs(ofs);
    assign sel_onehot  = NCH'(1) << wdata[1:0];

    // Command byte: CPU load, cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset)                 cmd <= '0;
        else if (wr && ofs == OFS_CMD_STAT)   cmd <= wdata;
    end

    // Request byte: CPU load, cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset)            req <= '0;
        else if (wr && ofs == OFS_REQ)   req <= wdata;
    end

    // Temporary register: only ever cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) temp <= '0;
    end

    // Status flags: sticky sets from the sequencer, master reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat <= '0;
        else if (mreset) stat <= seq_set_done;
        else             stat <= stat | seq_set_done;
    end

    // Byte pointer: toggles on channel access, cleared by offset 12 or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset)                    byte_hi <= 1'b0;
        else if (wr && ofs == OFS_PTR_CLR)       byte_hi <= 1'b0;
        else if (chan_access)                    byte_hi <= ~byte_hi;
    end

    // Mask: CPU paths computed first, sequencer sets OR'd on top.
    logic [NCH-1:0] mask_cpu;
    always_comb begin
        mask_cpu = mask;
        if (wr) begin
            case (ofs)
                OFS_MASK_ONE: mask_cpu = wdata[2] ? (mask | sel_onehot)
                                                  : (mask & ~sel_onehot);
                OFS_MASK_ALL: mask_cpu = wdata[NCH-1:0];
                OFS_MASK_CLR: mask_cpu = '0;
                OFS_MRESET:   mask_cpu = '1;
                default:      mask_cpu = mask;
            endcase
        end
    end

    // Mask register update with sequencer priority.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '1;
        else        mask <= mask_cpu | seq_set_mask;
    end

    // Per-channel mode registers, selected by data bits 1:0.
    for (genvar c = 0; c < NCH; c++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                modes[c*MODE_W +: MODE_W] <= '0;
            else if (wr && ofs == OFS_MODE && sel_onehot[c])
                modes[c*MODE_W +: MODE_W] <= wdata[DW-1:2];
        end
    end
endmodule

// File: rtl/dmac_rdmux.sv
// Module: registered read-data multiplexer.
// Assumes: rd_ok is a single-cycle accepted read; rdata holds otherwise.
module dmac_rdmux
    import dmac_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_ok,
    input  logic [OFS_W-1:0]      ofs,
    input  logic                  byte_hi,
    input  logic [NCH*2*DW-1:0]   cur_addr,
    input  logic [NCH*2*DW-1:0]   cur_cnt,
    input  logic [NCH-1:0]        stat,
    input  logic [DW-1:0]         temp,
    input  logic [NCH-1:0]        mask,
    output logic [DW-1:0]         rdata
);
    localparam int unsigned RW = 2 * DW;

    logic [DW-1:0] rd_next;
    logic [RW-1:0] word;
    logic [1:0]    ch;

    assign ch = ofs[2:1];

    // Select the addressed value for the current offset.
    always_comb begin
        word    = ofs[0] ? cur_cnt[ch*RW +: RW] : cur_addr[ch*RW +: RW];
        rd_next = '0;
        if (is_chan_ofs(ofs)) begin
            rd_next = byte_hi ? word[RW-1:DW] : word[DW-1:0];
        end else begin
            case (ofs)
                OFS_CMD_STAT: rd_next = {{(DW-NCH){1'b0}}, stat};
                OFS_MRESET:   rd_next = temp;
                OFS_MASK_ALL: rd_next = {{(DW-NCH){1'b0}}, mask};
                default:      rd_next = '0;
            endcase
        end
    end

    // Read data register: loads only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_ok) rdata <= rd_next;
    end
endmodule

// File: rtl/dmac_regbank.sv
// Module: top of the DMA register bank. Decodes the byte port, holds
// per-channel registers and controller registers, and exchanges current
// values and update strobes with a transfer sequencer.
// Assumes: rd and wr are single-cycle strobes; if both are high the write
// is performed and the read is dropped.
module dmac_regbank
    import dmac_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd,
    input  logic                   wr,
    input  logic [3:0]             ofs,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic [3:0]             seq_cnt_dec,
    input  logic [3:0]             seq_addr_inc,
    input  logic [3:0]             seq_addr_dec,
    input  logic [3:0]             seq_reload,
    input  logic [3:0]             seq_set_done,
    input  logic [3:0]             seq_set_mask,
    output logic [4*2*DW-1:0]      cur_addr_o,
    output logic [4*2*DW-1:0]      cur_cnt_o,
    output logic [4*(DW-2)-1:0]    mode_o,
    output logic [3:0]             mask_o,
    output logic [DW-1:0]          cmd_o,
    output logic [DW-1:0]          req_o
);
    localparam int unsigned RW = 2 * DW;

    logic          rd_ok;
    logic          byte_hi;
    logic [NCH-1:0] stat;
    logic [DW-1:0] temp;

    assign rd_ok = rd && !wr;

    // Per-channel register sets, decoded from offsets 2n and 2n+1.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmac_chan #(.DW(DW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cpu_wr_addr (wr && ofs == OFS_W'(2*c)),
            .cpu_wr_cnt  (wr && ofs == OFS_W'(2*c+1)),
            .byte_hi     (byte_hi),
            .wdata       (wdata),
            .addr_inc    (seq_addr_inc[c]),
            .addr_dec    (seq_addr_dec[c]),
            .cnt_dec     (seq_cnt_dec[c]),
            .reload      (seq_reload[c]),
            .cur_addr    (cur_addr_o[c*RW +: RW]),
            .cur_cnt     (cur_cnt_o[c*RW +: RW])
        );
    end

    dmac_ctrl #(.DW(DW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (wr),
        .rd_ok        (rd_ok),
        .ofs          (ofs),
        .wdata        (wdata),
        .seq_set_done (seq_set_done),
        .seq_set_mask (seq_set_mask),
        .cmd          (cmd_o),
        .req          (req_o),
        .stat         (stat),
        .temp         (temp),
        .mask         (mask_o),
        .modes        (mode_o),
        .byte_hi      (byte_hi)
    );

    dmac_rdmux #(.DW(DW)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ok    (rd_ok),
        .ofs      (ofs),
        .byte_hi  (byte_hi),
        .cur_addr (cur_addr_o),
        .cur_cnt  (cur_cnt_o),
        .stat     (stat),
        .temp     (temp),
        .mask     (mask_o),
        .rdata    (rdata)
    );
endmodule

// File: rtl/dmac_regbank_chk.sv
// Module: port-level assertions for dmac_regbank, attached by bind.
module dmac_regbank_chk #(
    parameter int unsigned DW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd,
    input logic                wr,
    input logic [3:0]          ofs,
    input logic [DW-1:0]       rdata,
    input logic [3:0]          seq_cnt_dec,
    input logic [3:0]          seq_reload,
    input logic [3:0]          seq_set_mask,
    input logic [4*2*DW-1:0]   cur_cnt_o,
    input logic [3:0]          mask_o,
    input logic [DW-1:0]       cmd_o,
    input logic [DW-1:0]       req_o
);
    localparam int unsigned RW = 2 * DW;

    // R1
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> mask_o == 4'hF);

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(rd) || $past(wr))) |-> $stable(rdata));

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(ofs) == 4'd14 && $past(seq_set_mask) == 4'h0)
        |-> mask_o == 4'h0);

    // R8
    master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(ofs) == 4'd13)
        |-> (mask_o == 4'hF && cmd_o == '0 && req_o == '0));

    for (genvar c = 0; c < 4; c++) begin : g_ch
        // R10
        cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(seq_cnt_dec[c]) && !$past(seq_reload[c]))
            |-> cur_cnt_o[c*RW +: RW] == $past(cur_cnt_o[c*RW +: RW]) - 1'b1);

        // R11
        seq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(seq_set_mask[c])) |-> mask_o[c]);
    end
endmodule

bind dmac_regbank dmac_regbank_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd           (rd),
    .wr           (wr),
    .ofs          (ofs),
    .rdata        (rdata),
    .seq_cnt_dec  (seq_cnt_dec),
    .seq_reload   (seq_reload),
    .seq_set_mask (seq_set_mask),
    .cur_cnt_o    (cur_cnt_o),
    .mask_o       (mask_o),
    .cmd_o        (cmd_o),
    .req_o        (req_o)
);

// File: tb/dmac_regbank_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares
// rdata on the falling edge after each accepted read.
module dmac_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [3:0]  ofs = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  seq_cnt_dec = '0, seq_addr_inc = '0, seq_addr_dec = '0;
    logic [3:0]  seq_reload = '0, seq_set_done = '0, seq_set_mask = '0;
    logic [63:0] cur_addr_o, cur_cnt_o;
    logic [23:0] mode_o;
    logic [3:0]  mask_o;
    logic [7:0]  cmd_o, req_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_acc = 1'b0;

    always #10 clk = ~clk;

    dmac_regbank u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: track accepted reads and compare the byte one cycle later.
    always @(posedge clk) rd_acc <= rd && !wr && rst_n;
    always @(negedge clk) begin
        if (rd_acc) begin
            if (exp_q.size() == 0) chk("scoreboard-empty", 1, 0);
            else chk(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
        end
    end

    task automatic wr_reg(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; ofs = o; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] o, input logic [7:0] e, input string tag);
        @(negedge clk); rd = 1'b1; ofs = o;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd = 1'b0;
    endtask

    function automatic logic [15:0] ca(input int c); return cur_addr_o[c*16 +: 16]; endfunction
    function automatic logic [15:0] cc(input int c); return cur_cnt_o[c*16 +: 16]; endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask_o", mask_o, 4'hF);
        chk("R1 cur_addr", cur_addr_o[31:0], 0);
        chk("R1 cur_cnt", cur_cnt_o[31:0], 0);
        rd_reg(4'd8, 8'h00, "R1 status");
        rd_reg(4'd15, 8'h0F, "R1 mask read");

        // R2 two-byte loads of channel 1
        wr_reg(4'd12, 8'h00);
        wr_reg(4'd2, 8'h34); wr_reg(4'd2, 8'h12);
        chk("R2 addr ch1", ca(1), 16'h1234);
        wr_reg(4'd3, 8'h05); wr_reg(4'd3, 8'h00);
        chk("R2 cnt ch1", cc(1), 16'h0005);

        // R3 byte pointer on reads and clear
        rd_reg(4'd2, 8'h34, "R3 low byte");
        rd_reg(4'd2, 8'h12, "R3 high byte");
        rd_reg(4'd2, 8'h34, "R3 low again");
        wr_reg(4'd12, 8'h00);
        rd_reg(4'd2, 8'h34, "R3 after clear");
        // R4 hold without read
        @(negedge clk); @(negedge clk);
        chk("R4 rdata held", rdata, 8'h34);
        wr_reg(4'd12, 8'h00);

        // R5 mode of channel 2
        wr_reg(4'd11, 8'hA6);
        chk("R5 mode ch2", mode_o[12 +: 6], 6'h29);
        chk("R5 mode ch0", mode_o[0 +: 6], 6'h00);

        // R7/R6 mask write paths
        wr_reg(4'd14, 8'hFF);
        chk("R7 mask clear", mask_o, 4'h0);
        wr_reg(4'd10, 8'h05);
        chk("R6 set ch1", mask_o, 4'h2);
        wr_reg(4'd10, 8'h01);
        chk("R6 clear ch1", mask_o, 4'h0);
        wr_reg(4'd15, 8'hF9);
        chk("R7 mask load", mask_o, 4'h9);
        rd_reg(4'd15, 8'h09, "R7 mask read");

        // R9 write-only offsets read zero
        rd_reg(4'd9, 8'h00, "R9 ofs9");
        rd_reg(4'd10, 8'h00, "R9 ofs10");
        rd_reg(4'd11, 8'h00, "R9 ofs11");
        rd_reg(4'd12, 8'h00, "R9 ofs12");
        rd_reg(4'd14, 8'h00, "R9 ofs14");

        // R12 command and request
        wr_reg(4'd8, 8'h04); wr_reg(4'd9, 8'h05);
        chk("R12 cmd", cmd_o, 8'h04);
        chk("R12 req", req_o, 8'h05);
        rd_reg(4'd8, 8'h00, "R12 ofs8 reads status");

        // R10 sequencer strobes
        @(negedge clk); seq_cnt_dec = 4'h2; @(negedge clk); seq_cnt_dec = 4'h0;
        chk("R10 cnt dec", cc(1), 16'h0004);
        @(negedge clk); seq_addr_inc = 4'h2; @(negedge clk); seq_addr_inc = 4'h0;
        chk("R10 addr inc", ca(1), 16'h1235);
        @(negedge clk); seq_addr_dec = 4'h2; @(negedge clk); @(negedge clk); seq_addr_dec = 4'h0;
        chk("R10 addr dec", ca(1), 16'h1233);
        @(negedge clk); seq_reload = 4'h2; @(negedge clk); seq_reload = 4'h0;
        chk("R10 reload addr", ca(1), 16'h1234);
        chk("R10 reload cnt", cc(1), 16'h0005);
        // R10 priority over same-cycle CPU byte write
        wr_reg(4'd12, 8'h00);
        @(negedge clk); wr = 1'b1; ofs = 4'd2; wdata = 8'h77; seq_addr_inc = 4'h2;
        @(negedge clk); wr = 1'b0; seq_addr_inc = 4'h0;
        chk("R10 seq wins", ca(1), 16'h1235);
        @(negedge clk); seq_reload = 4'h2; @(negedge clk); seq_reload = 4'h0;
        chk("R10 base still written", ca(1), 16'h1277);
        rd_reg(4'd2, 8'h12, "R3 pointer toggled by write");

        // R11 status and mask sets from the sequencer
        @(negedge clk); seq_set_done = 4'h4; @(negedge clk); seq_set_done = 4'h0;
        rd_reg(4'd8, 8'h04, "R11 status ch2");
        @(negedge clk); wr = 1'b1; ofs = 4'd10; wdata = 8'h00; seq_set_mask = 4'h1;
        @(negedge clk); wr = 1'b0; seq_set_mask = 4'h0;
        chk("R11 mask set wins", mask_o, 4'h9);

        // R8 master reset
        rd_reg(4'd2, 8'h77, "R8 pre low byte");
        wr_reg(4'd13, 8'h00);
        chk("R8 mask", mask_o, 4'hF);
        chk("R8 cmd", cmd_o, 8'h00);
        chk("R8 req", req_o, 8'h00);
        chk("R8 mode kept", mode_o[12 +: 6], 6'h29);
        chk("R8 addr kept", ca(1), 16'h1277);
        rd_reg(4'd8, 8'h00, "R8 status cleared");
        rd_reg(4'd13, 8'h00, "R8 temp read");
        wr_reg(4'd12, 8'h00);
        wr_reg(4'd13, 8'h00);
        rd_reg(4'd2, 8'h77, "R8 pointer cleared");

        @(negedge clk); @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule